// File: doc/BRIEF.md
# GPIO Interrupt Source Multiplexer

This block steers a wide bank of general-purpose input pins onto eight interrupt lines that go to an upstream interrupt controller. Each of the eight channels has its own source selector, which picks any one pin by an 8-bit index. The index value 255 means that the channel is disconnected. The picked pin passes through a two-stage synchroniser and an optional glitch filter. It then drives the channel output either as a level, with selectable polarity, or as a one-cycle pulse on one chosen transition direction. A channel has no mode that fires on both edges.

Software sets the channels up through a small 32-bit register port with four word addresses. One word holds the edge/level bits and the polarity bits as two separate bit-planes. Two words hold the eight source indexes, one byte per channel. One word holds the filter lengths, one nibble per channel. When a channel is pointed at a different pin, its detection pipeline is flushed and primed again from the new pin, so the change itself never looks like an edge.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, trigger word 0 and filter word 3 read 0x00000000, source words 1 and 2 read 0xFFFFFFFF (every channel unassigned), and all eight outputs are low.
- R2: Word 0 holds edge-mode bit c at bit c and active-low/falling bit c at bit 16+c. Word 1 holds the source of channel c (c = 0..3) in byte c, and word 2 holds the source of channel 4+c in byte c. Word 3 holds the 3-bit filter length of channel c in bits 4c+2..4c. Every other bit reads 0, so writing all ones reads back 0x00FF00FF from word 0 and 0x77777777 from word 3.
- R3: In edge mode with the polarity bit clear, and with filter length 0, a rising transition on the selected pin raises only that channel's output for exactly one cycle. The pulse is seen three clock edges after the pin changes. A falling transition gives no pulse.
- R4: In edge mode with the polarity bit set, only a falling transition gives the one-cycle pulse, with the same latency. A rising transition gives none.
- R5: In level mode the output equals the synchronised pin (three edges of latency), inverted when the polarity bit is set. A polarity write takes effect at the write edge.
- R6: A source index of 255, or any index at or above the number of pins, holds the channel output low in every mode, including active-low level mode.
- R7: Writing a new source index flushes the channel's synchroniser and filter, and primes them from the new pin. No pulse results even when the old and new pins differ in level, and later transitions on the new pin are detected normally.
- R8: With a filter length N in the range 1..7, a change on the pin must persist for 8·N sampled cycles before it is accepted. A level held for 8·N−1 cycles is discarded. An accepted rising edge pulses 2+8·N edges after the pin changes.
- R9: Read data appears on the cycle after the read strobe and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | NUM_GPIO | Asynchronous input pins |
| reg_addr | input | 2 | Word address of the register port |
| reg_wr | input | 1 | Write strobe, takes effect at the clock edge |
| reg_rd | input | 1 | Read strobe, data on the next cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 8 | Interrupt line of each channel |

## Verification
The bench keeps the defaults: 136 input pins and a filter step of 8 cycles. With 136 pins, an index of 200 is in range for the 8-bit selector but names no pin, and indexes above 127 are reachable. Every one of the 8×136 channel/pin pairs is swept in rising-edge mode, with the exact pulse cycle and the quiet state of the other channels checked. The step of 8 keeps all seven filter lengths short enough that the accept latency and the one-cycle-short glitch rejection are each measured for every length.

// File: rtl/gir_pkg.sv
package gir_pkg;

    localparam int NUM_CH  = 8;
    localparam int SEL_W   = 8;
    localparam int FLEN_W  = 3;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam logic [SEL_W-1:0] SEL_NONE = '1;

    // word addresses on the register port
    localparam logic [ADDR_W-1:0] A_TRIG = 2'd0;
    localparam logic [ADDR_W-1:0] A_SRCL = 2'd1;
    localparam logic [ADDR_W-1:0] A_SRCH = 2'd2;
    localparam logic [ADDR_W-1:0] A_FILT = 2'd3;

    // bit position of the polarity plane inside the trigger word
    localparam int POL_BASE = 16;
    localparam int NIB_W    = 4;

    typedef struct packed {
        logic              edge_mode;
        logic              act_low;
        logic [SEL_W-1:0]  src;
        logic [FLEN_W-1:0] flen;
    } chan_cfg_t;

    // number of stable cycles demanded by a filter setting
    function automatic int unsigned flt_cycles(input logic [FLEN_W-1:0] n,
                                               input int unsigned step);
        return int'(n) * step;
    endfunction

    // a selector names a real pin only below the pin count
    function automatic logic src_valid(input logic [SEL_W-1:0] s,
                                       input int unsigned npins);
        return (s != SEL_NONE) && (int'(s) < npins);
    endfunction

endpackage

// File: rtl/gir_regs.sv
module gir_regs
    import gir_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output chan_cfg_t [NUM_CH-1:0]    cfg
);
    localparam int HALF = NUM_CH / 2;

    logic [NUM_CH-1:0]    edge_q;
    logic [NUM_CH-1:0]    low_q;
    logic [SEL_W-1:0]     src_q  [NUM_CH];
    logic [FLEN_W-1:0]    flen_q [NUM_CH];
    logic [DATA_W-1:0]    rd_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= '0;
            low_q  <= '0;
            for (int c = 0; c < NUM_CH; c++) begin
                src_q[c]  <= SEL_NONE;
                flen_q[c] <= '0;
            end
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_TRIG: begin
                    edge_q <= reg_wdata[NUM_CH-1:0];
                    low_q  <= reg_wdata[POL_BASE +: NUM_CH];
                end
                A_SRCL: for (int c = 0; c < HALF; c++)
                            src_q[c] <= reg_wdata[SEL_W*c +: SEL_W];
                A_SRCH: for (int c = 0; c < HALF; c++)
                            src_q[HALF+c] <= reg_wdata[SEL_W*c +: SEL_W];
                A_FILT: for (int c = 0; c < NUM_CH; c++)
                            flen_q[c] <= reg_wdata[NIB_W*c +: FLEN_W];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (reg_addr)
            A_TRIG: begin
                rd_word[NUM_CH-1:0]         = edge_q;
                rd_word[POL_BASE +: NUM_CH] = low_q;
            end
            A_SRCL: for (int c = 0; c < HALF; c++)
                        rd_word[SEL_W*c +: SEL_W] = src_q[c];
            A_SRCH: for (int c = 0; c < HALF; c++)
                        rd_word[SEL_W*c +: SEL_W] = src_q[HALF+c];
            A_FILT: for (int c = 0; c < NUM_CH; c++)
                        rd_word[NIB_W*c +: FLEN_W] = flen_q[c];
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_word;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
        assign cfg[c].edge_mode = edge_q[c];
        assign cfg[c].act_low   = low_q[c];
        assign cfg[c].src       = src_q[c];
        assign cfg[c].flen      = flen_q[c];
    end

endmodule

// File: rtl/gir_filter.sv
module gir_filter #(
    parameter int TH_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            in_vld,
    input  logic            in_bit,
    input  logic [TH_W-1:0] thresh,
    output logic            flt,
    output logic            flt_vld,
    output logic            upd
);
    logic [TH_W-1:0] cnt;
    logic [TH_W:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flt     <= 1'b0;
            flt_vld <= 1'b0;
            cnt     <= '0;
            upd     <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (!in_vld) begin
                flt_vld <= 1'b0;
                cnt     <= '0;
            end else if (!flt_vld) begin
                // prime from the freshly synchronised pin, no event
                flt     <= in_bit;
                flt_vld <= 1'b1;
                cnt     <= '0;
            end else if (in_bit != flt) begin
                if (cnt_nxt >= {1'b0, thresh}) begin
                    flt <= in_bit;
                    upd <= 1'b1;
                    cnt <= '0;
                end else begin
                    cnt <= cnt_nxt[TH_W-1:0];
                end
            end else begin
                cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/gir_chan.sv
module gir_chan
    import gir_pkg::*;
#(
    parameter int NUM_GPIO  = 136,
    parameter int FILT_STEP = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_GPIO-1:0] gpio_in,
    input  chan_cfg_t           cfg,
    output logic                irq
);
    localparam int MAX_TH = ((1 << FLEN_W) - 1) * FILT_STEP;
    localparam int TH_W   = $clog2(MAX_TH + 2);
    localparam int FILL_N = 2;

    logic [SEL_W-1:0] src_prev;
    logic             chg;
    logic             src_ok;
    logic             raw;
    logic             s1, s2;
    logic [1:0]       fill;
    logic             s2_vld;
    logic [TH_W-1:0]  thresh;
    logic             flt, flt_vld, upd;
    logic             lvl_hit, edg_hit;

    assign src_ok = src_valid(cfg.src, NUM_GPIO);
    assign raw    = src_ok ? gpio_in[cfg.src] : 1'b0;
    assign chg    = (cfg.src != src_prev);

    always_ff @(posedge clk) begin
        if (rst) src_prev <= SEL_NONE;
        else     src_prev <= cfg.src;
    end

    // two-stage synchroniser with a fill count; flushed on reselection
    always_ff @(posedge clk) begin
        if (rst || chg) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            fill <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (fill != 2'(FILL_N)) fill <= fill + 1'b1;
        end
    end

    assign s2_vld = (fill == 2'(FILL_N));
    assign thresh = TH_W'(flt_cycles(cfg.flen, FILT_STEP));

    gir_filter #(.TH_W(TH_W)) u_filter (
        .clk     (clk),
        .rst     (rst),
        .clr     (chg),
        .in_vld  (s2_vld),
        .in_bit  (s2),
        .thresh  (thresh),
        .flt     (flt),
        .flt_vld (flt_vld),
        .upd     (upd)
    );

    // level: accepted value xor polarity; edge: accepted change whose new
    // value is the active one (high for rising, low for falling)
    assign lvl_hit = flt_vld && (flt ^ cfg.act_low);
    assign edg_hit = upd && (flt ^ cfg.act_low);
    assign irq     = src_ok && (cfg.edge_mode ? edg_hit : lvl_hit);

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gir_pkg::*;
#(
    parameter int NUM_GPIO  = 136,
    parameter int FILT_STEP = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_GPIO-1:0] gpio_in,
    input  logic [1:0]          reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [7:0]          irq_out
);
    chan_cfg_t [NUM_CH-1:0] cfg;

    gir_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        gir_chan #(
            .NUM_GPIO  (NUM_GPIO),
            .FILT_STEP (FILT_STEP)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .gpio_in (gpio_in),
            .cfg     (cfg[c]),
            .irq     (irq_out[c])
        );
    end

endmodule

// File: rtl/gir_checker.sv
module gir_checker
    import gir_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             reg_addr,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [31:0]            reg_wdata,
    input  logic [31:0]            reg_rdata,
    input  logic [7:0]             irq_out,
    input  chan_cfg_t [NUM_CH-1:0] cfg
);
    // R9: read data changes only on a read
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));

    // R2: a write to the low source word lands in channels 0..3
    p_sel_write_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_SRCL) |=>
        ({cfg[3].src, cfg[2].src, cfg[1].src, cfg[0].src} == $past(reg_wdata)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // R1: right after reset every channel is unassigned and quiet
        p_reset_sel_r1: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (cfg[c].src == SEL_NONE && !irq_out[c]));

        // R6: an unassigned channel never asserts
        p_unassigned_quiet_r6: assert property (@(posedge clk) disable iff (rst)
            (cfg[c].src == SEL_NONE) |-> !irq_out[c]);

        // R3: an edge-mode pulse lasts a single cycle
        p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
            (cfg[c].edge_mode && irq_out[c]) |=> !(cfg[c].edge_mode && irq_out[c]));

        // R8: filter length written into its nibble
        p_filt_write_r8: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_addr == A_FILT) |=>
            (cfg[c].flen == $past(reg_wdata[NIB_W*c +: FLEN_W])));
    end

endmodule

bind gpio_irq_router gir_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .cfg       (cfg)
);

// File: tb/gpio_irq_router_bench.sv
module gpio_irq_router_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NG         = 136;
    localparam int STEP       = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NG-1:0] gpio = '0;
    logic [1:0]    addr = '0;
    logic          wr = 1'b0, rd = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [7:0]    irq;
    int            total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_router #(.NUM_GPIO(NG), .FILT_STEP(STEP)) u_gpio_irq_router (
        .clk(clk), .rst(rst), .gpio_in(gpio), .reg_addr(addr), .reg_wr(wr),
        .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    // count cycles with the given output bit high over n cycles
    task automatic count_hits(input int ch, input int n, output int hits);
        hits = 0;
        for (int k = 0; k < n; k++) begin
            tick(1);
            if (irq[ch]) hits++;
        end
    endtask

    initial begin
        logic [31:0] d;
        int hits, first;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state, R9 read timing
        check("R1 irq after reset", {24'd0, irq}, 32'h0);
        rd_reg(2'd0, d); check("R1 trig word", d, 32'h0);
        rd_reg(2'd1, d); check("R1 src low word", d, 32'hFFFF_FFFF);
        rd_reg(2'd2, d); check("R1 src high word", d, 32'hFFFF_FFFF);
        rd_reg(2'd3, d); check("R1 filt word", d, 32'h0);
        wr_reg(2'd0, 32'h0000_00A5);
        tick(2);
        check("R9 rdata holds without read", rdata, 32'h0);

        // R2 field layout and read masks
        wr_reg(2'd0, 32'hFFFF_FFFF);
        rd_reg(2'd0, d); check("R2 trig mask", d, 32'h00FF_00FF);
        wr_reg(2'd3, 32'hFFFF_FFFF);
        rd_reg(2'd3, d); check("R2 filt mask", d, 32'h7777_7777);
        wr_reg(2'd2, 32'h1234_5678);
        rd_reg(2'd2, d); check("R2 src high word", d, 32'h1234_5678);
        wr_reg(2'd2, 32'hFFFF_FFFF);
        wr_reg(2'd3, 32'h0);

        // R3 sweep of every channel/pin pair, rising edge mode
        wr_reg(2'd0, 32'h0000_00FF);
        for (int ch = 0; ch < 8; ch++) begin
            for (int src = 0; src < NG; src++) begin
                logic [31:0] wl, wh;
                wl = 32'hFFFF_FFFF; wh = 32'hFFFF_FFFF;
                if (ch < 4) wl[8*ch +: 8] = 8'(src);
                else        wh[8*(ch-4) +: 8] = 8'(src);
                wr_reg(2'd1, wl);
                wr_reg(2'd2, wh);
                tick(6);
                gpio[src] = 1'b1;
                tick(3);
                check($sformatf("R3 pulse ch%0d src%0d", ch, src), {24'd0, irq}, 32'(1 << ch));
                tick(1);
                check($sformatf("R3 pulse end ch%0d src%0d", ch, src), {24'd0, irq}, 32'h0);
                gpio[src] = 1'b0;
                count_hits(ch, 4, hits);
                check($sformatf("R3 no fall pulse ch%0d src%0d", ch, src), hits, 0);
            end
        end
        wr_reg(2'd1, 32'hFFFF_FFFF);
        wr_reg(2'd2, 32'hFFFF_FFFF);

        // R4 falling edge on channel 1, pin 130
        wr_reg(2'd0, 32'h0002_0002);
        wr_reg(2'd1, 32'hFFFF_82FF);
        tick(6);
        gpio[130] = 1'b1;
        count_hits(1, 6, hits);
        check("R4 rising ignored", hits, 0);
        gpio[130] = 1'b0;
        tick(3);
        check("R4 falling pulse", {24'd0, irq}, 32'h02);
        tick(1);
        check("R4 pulse one cycle", {24'd0, irq}, 32'h0);

        // R5 level mode on channel 2, pin 132
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd1, 32'hFF84_FFFF);
        tick(6);
        check("R5 level idle", {24'd0, irq}, 32'h0);
        gpio[132] = 1'b1;
        tick(2);
        check("R5 level not yet", {24'd0, irq}, 32'h0);
        tick(1);
        check("R5 level high", {24'd0, irq}, 32'h04);
        gpio[132] = 1'b0;
        tick(3);
        check("R5 level back low", {24'd0, irq}, 32'h0);
        wr_reg(2'd0, 32'h0004_0000);
        check("R5 active low at write", {24'd0, irq}, 32'h04);

        // R6 unassigned and out-of-range selectors, channel 3 level low
        wr_reg(2'd0, 32'h0008_0000);
        wr_reg(2'd1, 32'hFFFF_FFFF);
        tick(6);
        check("R6 index 255 quiet", {24'd0, irq}, 32'h0);
        wr_reg(2'd1, 32'hC8FF_FFFF);
        tick(6);
        check("R6 index 200 quiet", {24'd0, irq}, 32'h0);
        wr_reg(2'd1, 32'h87FF_FFFF);
        tick(6);
        check("R6 last pin active low", {24'd0, irq}, 32'h08);
        gpio[135] = 1'b1;
        tick(3);
        check("R6 last pin high", {24'd0, irq}, 32'h0);
        gpio[135] = 1'b0;
        wr_reg(2'd1, 32'hFFFF_FFFF);

        // R7 reselection from a low pin to a high pin, channel 4
        wr_reg(2'd0, 32'h0000_0010);
        wr_reg(2'd2, 32'hFFFF_FF0A);
        gpio[20] = 1'b1;
        tick(6);
        wr_reg(2'd2, 32'hFFFF_FF14);
        count_hits(4, 10, hits);
        check("R7 no spurious pulse", hits, 0);
        gpio[20] = 1'b0;
        tick(4);
        gpio[20] = 1'b1;
        tick(3);
        check("R7 new pin detected", {24'd0, irq}, 32'h10);
        gpio[20] = 1'b0;
        wr_reg(2'd2, 32'hFFFF_FFFF);

        // R8 glitch filter, channel 0, pin 5, every length
        wr_reg(2'd0, 32'h0000_0001);
        wr_reg(2'd1, 32'hFFFF_FF05);
        tick(6);
        for (int n = 1; n < 8; n++) begin
            wr_reg(2'd3, 32'(n));
            tick(2);
            gpio[5] = 1'b1;
            tick(STEP*n - 1);
            gpio[5] = 1'b0;
            count_hits(0, STEP*n + 6, hits);
            check($sformatf("R8 glitch rejected n=%0d", n), hits, 0);
            gpio[5] = 1'b1;
            first = -1;
            for (int k = 1; k <= STEP*n + 6; k++) begin
                tick(1);
                if (irq[0] && first < 0) first = k;
            end
            check($sformatf("R8 accept latency n=%0d", n), first, 2 + STEP*n);
            gpio[5] = 1'b0;
            tick(STEP*n + 6);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule